// File: doc/BRIEF.md
# Keypad Combination Lock Controller

This block is a synchronous controller for a three-key combination lock. Debounced key strobes arrive as a one-cycle valid pulse with a 2-bit key code. The controller gathers three symbols, compares them in order with a stored code, and then either pulses an open output or counts a failed attempt. Three one-hot indicator outputs show which symbol of the code the lock expects next.

A program-mode input lets the user replace the stored code. While it is high, the next three accepted presses are written in order into the code memory. No open pulse is produced and the failed-attempt state does not change. The third wrong entry since the last correct one raises an alarm. The alarm stays raised until a correct entry clears it.

Top module: `combo_lock_ctrl`

## Requirements
- R1: After reset, the stored code is A-A-A, the indicator shows the first position (pos_o = 3'b001), and open_o and alarm_o are low.
- R2: pos_o is always one-hot. Each accepted press moves it up one position (bit 0, then bit 1, then bit 2). After the third press it returns to bit 0.
- R3: Key codes are A=0, B=1 and C=2. A strobe that carries code 3 is ignored: the position, the partial match and the stored code are all left unchanged.
- R4: While prog_i is high, accepted presses are written into code positions 1, 2 and 3 in order. No open pulse occurs and the failed-attempt count is unchanged. In the cycle where prog_i differs from its previous value, the position returns to the first symbol and any key strobe in that cycle is ignored.
- R5: A wrong symbol does not end an entry early. The lock always waits for three accepted presses before it judges the entry.
- R6: When all three symbols of an entry match the stored code in order, open_o is high for exactly one cycle, in the cycle after the third press is sampled.
- R7: A correct entry clears the alarm and the failed-attempt count in the same cycle that open_o is asserted.
- R8: Each complete wrong entry raises the failed-attempt count, which stops at three. alarm_o is high while the count is three, so it rises on the third wrong entry since the last correct one and stays high through further wrong entries.
- R9: A complete entry that differs from the stored code in any position never asserts open_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| key_valid_i | input | 1 | One-cycle strobe: a key was pressed |
| key_code_i | input | 2 | Key symbol: A=0, B=1, C=2; 3 is ignored |
| prog_i | input | 1 | High while a new code is being entered |
| open_o | output | 1 | One-cycle pulse for the actuator |
| alarm_o | output | 1 | High after three wrong entries, until a correct one |
| pos_o | output | 3 | One-hot position of the next expected symbol |

## Verification
Every output comes from a register loaded at the clock edge that samples the key strobe. The updated position, open pulse and alarm level are therefore visible one cycle after the strobe is driven. The driver applies each stimulus on the falling edge. At the same moment it queues the outputs that a model built from the requirements predicts for the next rising edge. The monitor takes each queued item one nanosecond after that rising edge and compares it there, so every check looks at exactly one edge. Idle cycles are queued as well, which shows that the open pulse has dropped again one cycle later.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int KEY_W      = 2;
    localparam int NUM_KEYS   = 3;
    localparam int CODE_LEN   = 3;
    localparam int FAIL_LIMIT = 3;

    typedef logic [KEY_W-1:0] key_t;

    typedef struct packed {
        logic prog;   // registered program-mode level
        logic match;  // all symbols so far matched
        logic open;   // open pulse
    } ctl_t;
endpackage

// File: rtl/lock_pos_ctr.sv
module lock_pos_ctr #(
    parameter int CODE_LEN = 3,
    localparam int IDX_W   = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clear_i,
    input  logic                adv_i,
    output logic [IDX_W-1:0]    idx_o,
    output logic                last_o,
    output logic [CODE_LEN-1:0] pos_oh_o
);
    logic [IDX_W-1:0] idx_d, idx_q;

    assign last_o = (idx_q == IDX_W'(CODE_LEN - 1));

    always_comb begin
        idx_d = idx_q;
        if (clear_i) begin
            idx_d = '0;
        end else if (adv_i) begin
            idx_d = last_o ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) idx_q <= '0;
        else         idx_q <= idx_d;
    end

    for (genvar i = 0; i < CODE_LEN; i++) begin : g_oh
        assign pos_oh_o[i] = (idx_q == IDX_W'(i));
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/lock_code_mem.sv
module lock_code_mem #(
    parameter int CODE_LEN = 3,
    parameter int KEY_W    = 2,
    localparam int IDX_W   = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [KEY_W-1:0] wr_sym_i,
    output logic [KEY_W-1:0] rd_sym_o
);
    logic [KEY_W-1:0] mem_d [CODE_LEN];
    logic [KEY_W-1:0] mem_q [CODE_LEN];

    always_comb begin
        for (int i = 0; i < CODE_LEN; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en_i && (idx_i == IDX_W'(i))) mem_d[i] = wr_sym_i;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < CODE_LEN; i++) begin
            if (!rst_ni) mem_q[i] <= '0;
            else         mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_sym_o = '0;
        for (int i = 0; i < CODE_LEN; i++) begin
            if (idx_i == IDX_W'(i)) rd_sym_o = mem_q[i];
        end
    end
endmodule

// File: rtl/lock_fail_ctr.sv
module lock_fail_ctr #(
    parameter int FAIL_LIMIT = 3,
    localparam int CNT_W     = $clog2(FAIL_LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pass_i,
    input  logic fail_i,
    output logic alarm_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_W'(FAIL_LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (pass_i) begin
            cnt_d = '0;
        end else if (fail_i && !at_limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign alarm_o = at_limit;
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter int NKEYS    = NUM_KEYS,
    parameter int CLEN     = CODE_LEN,
    parameter int FLIMIT   = FAIL_LIMIT,
    localparam int IDX_W   = (CLEN > 1) ? $clog2(CLEN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             key_valid_i,
    input  logic [KEY_W-1:0] key_code_i,
    input  logic             prog_i,
    output logic             open_o,
    output logic             alarm_o,
    output logic [CLEN-1:0]  pos_o
);
    ctl_t             ctl_d, ctl_q;
    logic [IDX_W-1:0] idx;
    logic             last;
    key_t             stored_sym;
    logic             prog_edge;
    logic             accept;
    logic             hit;
    logic             pass, fail;

    assign prog_edge = (prog_i != ctl_q.prog);
    assign accept    = key_valid_i && (int'(key_code_i) < NKEYS) && !prog_edge;
    assign hit       = ctl_q.match && (key_code_i == stored_sym);
    assign pass      = accept && !prog_i && last && hit;
    assign fail      = accept && !prog_i && last && !hit;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.prog = prog_i;
        ctl_d.open = 1'b0;
        if (prog_edge) begin
            ctl_d.match = 1'b1;
        end else if (accept && !prog_i) begin
            ctl_d.match = last ? 1'b1 : hit;
            ctl_d.open  = pass;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '{prog: 1'b0, match: 1'b1, open: 1'b0};
        else         ctl_q <= ctl_d;
    end

    lock_pos_ctr #(.CODE_LEN(CLEN)) u_pos (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (prog_edge),
        .adv_i    (accept),
        .idx_o    (idx),
        .last_o   (last),
        .pos_oh_o (pos_o)
    );

    lock_code_mem #(.CODE_LEN(CLEN), .KEY_W(KEY_W)) u_mem (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (accept && prog_i),
        .idx_i    (idx),
        .wr_sym_i (key_code_i),
        .rd_sym_o (stored_sym)
    );

    lock_fail_ctr #(.FAIL_LIMIT(FLIMIT)) u_fail (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pass_i  (pass),
        .fail_i  (fail),
        .alarm_o (alarm_o)
    );

    assign open_o = ctl_q.open;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
    parameter int NKEYS = 3,
    parameter int CLEN  = 3
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            key_valid_i,
    input logic [1:0]      key_code_i,
    input logic            prog_i,
    input logic            prog_q,
    input logic            open_o,
    input logic            alarm_o,
    input logic [CLEN-1:0] pos_o
);
    AST_POS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(pos_o) == 1); // R2

    AST_BAD_KEY_HOLDS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_valid_i && int'(key_code_i) >= NKEYS && prog_i == prog_q) |=> $stable(pos_o)); // R3

    AST_PROG_NO_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_i |=> !open_o); // R4

    AST_OPEN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_o |=> !open_o); // R6

    AST_OPEN_NO_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_o |-> !alarm_o); // R7

    AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_o |=> (alarm_o || open_o)); // R8

    AST_OPEN_AT_FIRST_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_o |-> pos_o[0]); // R5
endmodule

bind combo_lock_ctrl combo_lock_chk #(.NKEYS(NKEYS), .CLEN(CLEN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_valid_i (key_valid_i),
    .key_code_i  (key_code_i),
    .prog_i      (prog_i),
    .prog_q      (ctl_q.prog),
    .open_o      (open_o),
    .alarm_o     (alarm_o),
    .pos_o       (pos_o)
);

// File: tb/combo_lock_ctrl_tb.sv
module combo_lock_ctrl_tb;
    typedef struct {
        logic       open;
        logic       alarm;
        logic [2:0] pos;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       key_valid = 1'b0;
    logic [1:0] key_code = 2'd0;
    logic       prog = 1'b0;
    logic       open_o, alarm_o;
    logic [2:0] pos_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t q[$];

    // bench-side model of the requirements
    logic [1:0] m_code [3];
    int         m_pos, m_fail;
    logic       m_match, m_prog;

    always #2 clk = ~clk;

    combo_lock_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .key_valid_i(key_valid), .key_code_i(key_code),
        .prog_i(prog), .open_o(open_o), .alarm_o(alarm_o), .pos_o(pos_o)
    );

    task automatic step(input logic v, input logic [1:0] c, input logic p, input string tag);
        exp_t e;
        logic op;
        logic hit;
        @(negedge clk);
        key_valid = v; key_code = c; prog = p;
        op = 1'b0;
        if (p != m_prog) begin
            m_pos = 0; m_match = 1'b1;
        end else if (v && c != 2'd3) begin
            if (p) begin
                m_code[m_pos] = c;
                m_pos = (m_pos == 2) ? 0 : m_pos + 1;
            end else begin
                hit = m_match && (c == m_code[m_pos]);
                if (m_pos == 2) begin
                    if (hit) begin op = 1'b1; m_fail = 0; end
                    else if (m_fail < 3) m_fail++;
                    m_pos = 0; m_match = 1'b1;
                end else begin
                    m_match = hit; m_pos++;
                end
            end
        end
        m_prog = p;
        e.open = op; e.alarm = (m_fail == 3); e.pos = 3'(1 << m_pos); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic press(input logic [1:0] c, input string tag);
        step(1'b1, c, prog, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'd0, prog, tag);
    endtask

    task automatic entry(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input string tag);
        press(a, tag); press(b, tag); press(c, tag); idle(tag);
    endtask

    // monitor: compare one queued item just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (open_o !== e.open || alarm_o !== e.alarm || pos_o !== e.pos) begin
                    n_fail++;
                    $display("FAIL %s: got open=%b alarm=%b pos=%b, expected open=%b alarm=%b pos=%b",
                             e.tag, open_o, alarm_o, pos_o, e.open, e.alarm, e.pos);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) m_code[i] = 2'd0;
        m_pos = 0; m_fail = 0; m_match = 1'b1; m_prog = 1'b0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        #1;
        n_run++;
        if (open_o !== 1'b0 || alarm_o !== 1'b0 || pos_o !== 3'b001) begin
            n_fail++;
            $display("FAIL R1 reset: got open=%b alarm=%b pos=%b, expected 0 0 001", open_o, alarm_o, pos_o);
        end
        entry(2'd0, 2'd0, 2'd0, "R1 default code A-A-A opens / R6");
        // program A-B-A
        step(1'b0, 2'd0, 1'b1, "R4 enter program mode");
        entry(2'd0, 2'd1, 2'd0, "R4 write code A-B-A, no open");
        step(1'b0, 2'd0, 1'b0, "R4 leave program mode");
        // wrong, with a code-3 strobe in the middle
        press(2'd0, "R2 first symbol");
        press(2'd3, "R3 code 3 ignored");
        press(2'd1, "R2 second symbol");
        press(2'd2, "R9 A-B-C does not open");
        idle("R9 idle");
        entry(2'd1, 2'd2, 2'd1, "R5 wrong first symbol waits for three");
        entry(2'd2, 2'd1, 2'd1, "R8 third wrong raises alarm");
        entry(2'd2, 2'd2, 2'd2, "R8 alarm held, count saturates");
        entry(2'd0, 2'd1, 2'd0, "R7 correct A-B-A opens and clears alarm");
        // count frozen across program mode
        entry(2'd1, 2'd1, 2'd1, "R8 wrong 1");
        entry(2'd1, 2'd1, 2'd1, "R8 wrong 2");
        step(1'b0, 2'd0, 1'b1, "R4 enter program mode");
        entry(2'd2, 2'd2, 2'd1, "R4 write code C-C-B");
        step(1'b1, 2'd0, 1'b0, "R4 key on mode change ignored");
        entry(2'd0, 2'd0, 2'd0, "R4 count held, third wrong alarms");
        // leave program mode partway through
        step(1'b0, 2'd0, 1'b1, "R4 enter program mode");
        press(2'd2, "R4 partial write");
        step(1'b0, 2'd0, 1'b0, "R4 leaving mid-entry resets position");
        entry(2'd2, 2'd2, 2'd1, "R6 C-C-B opens, R7 clears alarm");
        idle("R6 open pulse gone");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule